// File: doc/BRIEF.md
# Three-Step Combination Lock

The block is a synchronous lock that opens only after three correct values have been entered in order. Three code values come in as steady inputs. A controller drives a 2-bit select that steers one of the three codes into an equality comparator. The comparator tests the selected code against the value the user has entered. Each entry is taken on the clock edge where the entry strobe is high. A matching entry moves the lock one step forward. A mismatching entry drops it into a failure state that only a restart can leave. After three matches the lock reaches an open state and stays there until restart.

Two controllers are provided and a parameter picks one of them. The first is a compact binary state machine with 3 state bits, built from fixed sum-of-products next-state equations. The second is a 4-bit one-hot shift register. Its bit pattern drives the select directly, each step is a right shift, and a failure clears the whole register. On the ports the two behave the same. The one exception is the select value while the lock is in the failure state. The asynchronous active-low reset and the synchronous restart input both return the lock to its first step.

Top module: `combo_lock`

## Requirements
- R1: After the asynchronous reset rst_ni is released, open_o is 0 and sel_o is 2'b01 (first code selected).
- R2: sel_o is 2'b01 while the lock waits for the first value, 2'b10 while it waits for the second and 2'b11 while it waits for the third, in both controller variants.
- R3: In a waiting step, a clock edge with new_i low leaves open_o and sel_o unchanged, whatever entry_i holds.
- R4: In a waiting step, a clock edge with new_i high and entry_i equal to the selected code advances the lock to the next step, or from the third step to the open state. The new outputs are visible after that edge.
- R5: In a waiting step, a clock edge with new_i high and entry_i different from the selected code moves the lock to the failure state. There open_o is 0, and sel_o is 2'b00 in the binary variant (CTRL_ONEHOT=0) and 2'b11 in the one-hot variant (CTRL_ONEHOT=1).
- R6: The open state gives open_o = 1 and sel_o = 2'b11. open_o is 1 in no other state.
- R7: The open state is kept through any further entries, matching or not, until restart or reset.
- R8: The failure state is kept through any further entries, including the correct code sequence, until restart or reset.
- R9: Fed the same inputs, the two variants always produce the same open_o. They produce the same sel_o in every state except the failure state.
- R10: restart_i high at a clock edge returns the lock to the first step (open_o 0, sel_o 2'b01) from any state and takes priority over new_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| restart_i | input | 1 | Synchronous restart to first step |
| new_i | input | 1 | Entry strobe; entry_i is taken at this edge |
| entry_i | input | VAL_W | Value entered by the user |
| code1_i | input | VAL_W | First code value |
| code2_i | input | VAL_W | Second code value |
| code3_i | input | VAL_W | Third code value |
| open_o | output | 1 | 1 when unlocked |
| sel_o | output | 2 | Code select driven by the controller |

## Verification
The bench targets a mismatch at each of the three steps. A controller that decodes a step wrongly would either open early or fail to drop into the failure state, and the wrong select value would show it. It holds entry_i at wrong values while the strobe is low, which catches a design that samples without new_i. It feeds the correct sequence after a failure and after the lock has opened, so a failure or open state that is not absorbing shows up as a spurious open or a changed select. It applies restart together with a matching strobe to catch a design that lets the strobe override restart. Both variants run in lockstep against one model, so a shift register that shifts in the wrong direction, or does not clear on a mismatch, breaks agreement with the binary variant.

// File: rtl/lock_pkg.sv
package lock_pkg;
  localparam int unsigned NUM_CODES = 3;
  localparam int unsigned SEL_W     = $clog2(NUM_CODES + 1);
  localparam int unsigned BIN_W     = 3;
  localparam int unsigned OH_W      = NUM_CODES + 1;

  localparam logic [SEL_W-1:0] SEL_C1 = 2'b01;
  localparam logic [SEL_W-1:0] SEL_C2 = 2'b10;
  localparam logic [SEL_W-1:0] SEL_C3 = 2'b11;

  localparam logic [BIN_W-1:0] ST_ERR  = 3'b000;
  localparam logic [BIN_W-1:0] ST_S1   = 3'b001;
  localparam logic [BIN_W-1:0] ST_S2   = 3'b010;
  localparam logic [BIN_W-1:0] ST_S3   = 3'b011;
  localparam logic [BIN_W-1:0] ST_OPEN = 3'b111;

  localparam logic [OH_W-1:0] OH_S1 = {1'b1, {(OH_W-1){1'b0}}};
endpackage

// File: rtl/lock_code_cmp.sv
module lock_code_cmp
  import lock_pkg::*;
#(
  parameter int unsigned VAL_W = 8
) (
  input  logic [SEL_W-1:0] sel_i,
  input  logic [VAL_W-1:0] code1_i,
  input  logic [VAL_W-1:0] code2_i,
  input  logic [VAL_W-1:0] code3_i,
  input  logic [VAL_W-1:0] entry_i,
  output logic             equal_o
);
  logic [VAL_W-1:0] picked;

  always_comb begin
    unique case (sel_i)
      SEL_C1:  picked = code1_i;
      SEL_C2:  picked = code2_i;
      SEL_C3:  picked = code3_i;
      default: picked = code1_i;
    endcase
  end

  assign equal_o = (picked == entry_i);
endmodule

// File: rtl/lock_ctrl_bin.sv
module lock_ctrl_bin
  import lock_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic             new_i,
  input  logic             equal_i,
  output logic             open_o,
  output logic [SEL_W-1:0] sel_o
);
  logic [BIN_W-1:0] st_q;
  logic [BIN_W-1:0] st_d;
  logic r, n, e;

  assign r = restart_i;
  assign n = new_i;
  assign e = equal_i;

  // two-level next-state equations, unreachable codes as don't-cares
  always_comb begin
    st_d[2] = ~r & ((n & e & st_q[1] & st_q[0]) | st_q[2]);
    st_d[1] = ~r & ((n & e & st_q[0]) | (e & st_q[1]) | (~n & st_q[1]) | st_q[2]);
    st_d[0] = r | st_q[2] | (n & e & st_q[1]) | (~n & st_q[0]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_S1;
    else         st_q <= st_d;
  end

  assign sel_o  = st_q[1:0];
  assign open_o = st_q[2];

  logic waiting;
  assign waiting = (st_q == ST_S1) || (st_q == ST_S2) || (st_q == ST_S3);

  assert_bin_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (waiting && !new_i && !restart_i) |=> $stable(st_q));
  assert_bin_adv_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_S1 && new_i && equal_i && !restart_i) |=> (st_q == ST_S2));
  assert_bin_fail_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (waiting && new_i && !equal_i && !restart_i) |=> (st_q == ST_ERR));
  assert_bin_open_keep_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_OPEN && !restart_i) |=> (st_q == ST_OPEN));
  assert_bin_err_keep_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_ERR && !restart_i) |=> (st_q == ST_ERR));
  assert_bin_restart_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (st_q == ST_S1));
endmodule

// File: rtl/lock_ctrl_onehot.sv
module lock_ctrl_onehot
  import lock_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic             new_i,
  input  logic             equal_i,
  output logic             open_o,
  output logic [SEL_W-1:0] sel_o
);
  logic [OH_W-1:0] sr_q;
  logic            shift_en, clear_en;

  assign open_o   = sr_q[0];
  assign shift_en = ~open_o & new_i;
  assign clear_en = ~open_o & new_i & ~equal_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       sr_q <= OH_S1;
    else if (restart_i) sr_q <= OH_S1;
    else if (clear_en) sr_q <= '0;
    else if (shift_en) sr_q <= {1'b0, sr_q[OH_W-1:1]};
  end

  // select is read straight from the register bits
  assign sel_o = {~sr_q[OH_W-1], ~sr_q[OH_W-2]};

  assert_oh_onehot_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sr_q));
  assert_oh_fail_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clear_en && !restart_i) |=> (sr_q == '0));
  assert_oh_open_keep_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (open_o && !restart_i) |=> open_o);
  assert_oh_err_keep_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sr_q == '0 && !restart_i) |=> (sr_q == '0));
  assert_oh_restart_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (sr_q == OH_S1));
endmodule

// File: rtl/combo_lock.sv
module combo_lock
  import lock_pkg::*;
#(
  parameter int unsigned VAL_W       = 8,
  parameter bit          CTRL_ONEHOT = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic             new_i,
  input  logic [VAL_W-1:0] entry_i,
  input  logic [VAL_W-1:0] code1_i,
  input  logic [VAL_W-1:0] code2_i,
  input  logic [VAL_W-1:0] code3_i,
  output logic             open_o,
  output logic [1:0]       sel_o
);
  logic             equal;
  logic [SEL_W-1:0] sel;
  logic             open_l;

  lock_code_cmp #(.VAL_W(VAL_W)) u_cmp (
    .sel_i   (sel),
    .code1_i (code1_i),
    .code2_i (code2_i),
    .code3_i (code3_i),
    .entry_i (entry_i),
    .equal_o (equal)
  );

  if (CTRL_ONEHOT) begin : g_onehot
    lock_ctrl_onehot u_ctrl (
      .clk_i, .rst_ni, .restart_i, .new_i,
      .equal_i (equal),
      .open_o  (open_l),
      .sel_o   (sel)
    );
  end else begin : g_bin
    lock_ctrl_bin u_ctrl (
      .clk_i, .rst_ni, .restart_i, .new_i,
      .equal_i (equal),
      .open_o  (open_l),
      .sel_o   (sel)
    );
  end

  assign open_o = open_l;
  assign sel_o  = sel;

  assert_open_sel_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    open_o |-> (sel_o == SEL_C3));
  assert_open_rise_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(open_o) |-> ($past(sel_o) == SEL_C3 && $past(new_i) && $past(equal)));
endmodule

// File: tb/combo_lock_tb_top.sv
`timescale 1ns/1ps
module combo_lock_tb_top;
  localparam int VW = 8;
  localparam logic [VW-1:0] C1 = 8'hA5, C2 = 8'h3C, C3 = 8'hF0;

  localparam int M_S1 = 0, M_S2 = 1, M_S3 = 2, M_OPEN = 3, M_ERR = 4;

  logic clk = 0, rst_n = 0, restart = 0, nw = 0;
  logic [VW-1:0] entry = '0;
  logic open_b, open_h;
  logic [1:0] sel_b, sel_h;
  int checks = 0, fails = 0, mst = M_S1;
  bit done = 0;

  always #2.5 clk = ~clk;

  combo_lock #(.VAL_W(VW), .CTRL_ONEHOT(1'b0)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .restart_i(restart), .new_i(nw), .entry_i(entry),
    .code1_i(C1), .code2_i(C2), .code3_i(C3), .open_o(open_b), .sel_o(sel_b));
  combo_lock #(.VAL_W(VW), .CTRL_ONEHOT(1'b1)) dut_oh_i (
    .clk_i(clk), .rst_ni(rst_n), .restart_i(restart), .new_i(nw), .entry_i(entry),
    .code1_i(C1), .code2_i(C2), .code3_i(C3), .open_o(open_h), .sel_o(sel_h));

  function automatic logic [VW-1:0] code_of(int s);
    return (s == M_S1) ? C1 : (s == M_S2) ? C2 : C3;
  endfunction

  task automatic chk(input string req, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic check_all(input string req);
    logic eo; logic [1:0] es_b, es_h;
    eo = (mst == M_OPEN);
    case (mst)
      M_S1: begin es_b = 2'b01; es_h = 2'b01; end
      M_S2: begin es_b = 2'b10; es_h = 2'b10; end
      M_S3, M_OPEN: begin es_b = 2'b11; es_h = 2'b11; end
      default: begin es_b = 2'b00; es_h = 2'b11; end
    endcase
    chk({req, " bin open"}, {2'b0, open_b}, {2'b0, eo});
    chk({req, " bin sel"},  {1'b0, sel_b},  {1'b0, es_b});
    chk({req, " oh open"},  {2'b0, open_h}, {2'b0, eo});
    chk({req, " oh sel"},   {1'b0, sel_h},  {1'b0, es_h});
    chk("R9 open lockstep", {2'b0, open_b}, {2'b0, open_h});
    if (mst != M_ERR) chk("R9 sel lockstep", {1'b0, sel_b}, {1'b0, sel_h});
  endtask

  // one clock: drive after negedge, check 1ns after posedge
  task automatic step(input logic n, input logic [VW-1:0] v, input logic rs, input string req);
    @(negedge clk);
    nw = n; entry = v; restart = rs;
    @(posedge clk);
    if (rs) mst = M_S1;
    else if (n && mst <= M_S3) mst = (v == code_of(mst)) ? mst + 1 : M_ERR;
    #1;
    nw = 0; restart = 0;
    check_all(req);
  endtask

  task automatic t_reset;
    rst_n = 0; mst = M_S1;
    repeat (3) @(posedge clk);
    #1 check_all("R1 in reset");
    @(negedge clk) rst_n = 1;
    @(posedge clk); #1 check_all("R1 after release");
  endtask

  task automatic t_unlock;
    step(0, 8'h00, 1, "R10 prep");
    step(1, C1, 0, "R2 R4 step1");
    step(1, C2, 0, "R2 R4 step2");
    step(1, C3, 0, "R6 opened");
  endtask

  task automatic t_hold;
    step(0, 8'h00, 1, "R10 prep");
    step(0, 8'h11, 0, "R3 hold s1");
    step(1, C1, 0, "R4 to s2");
    step(0, 8'hFF, 0, "R3 hold s2");
    step(0, C1, 0, "R3 hold s2 b");
    step(1, C2, 0, "R4 to s3");
    step(0, 8'h00, 0, "R3 hold s3");
    step(1, C3, 0, "R6 open");
  endtask

  task automatic t_fail(input int at);
    step(0, 8'h00, 1, "R10 prep");
    for (int k = 0; k < at; k++) step(1, code_of(k), 0, "R4 pre-fail");
    step(1, code_of(at) ^ 8'h01, 0, "R5 mismatch");
  endtask

  task automatic t_err_keep;
    t_fail(0);
    step(1, C1, 0, "R8 keep");
    step(1, C2, 0, "R8 keep");
    step(1, C3, 0, "R8 keep no open");
    step(0, 8'h00, 0, "R8 idle");
  endtask

  task automatic t_open_keep;
    t_unlock();
    step(1, 8'h00, 0, "R7 wrong in open");
    step(1, C1, 0, "R7 right in open");
    step(0, 8'h5A, 0, "R7 idle");
  endtask

  task automatic t_restart;
    t_unlock();
    step(0, 8'h00, 1, "R10 from open");
    step(1, C1, 0, "R4 after restart");
    step(1, C2, 1, "R10 beats new");
    t_fail(1);
    step(0, 8'h00, 1, "R10 from err");
    step(1, C1, 0, "R4 after err restart");
  endtask

  initial begin
    t_reset();
    t_unlock();
    t_hold();
    t_fail(0);
    t_fail(1);
    t_fail(2);
    t_err_keep();
    t_open_keep();
    t_restart();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog act=hung exp=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule